// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sets the number of bus-clock cycles each memory access lasts. An access request carries three things: a region code, a chip-select index and a flag for a multiplexed or separate bus. The controller turns these into a cycle count and works it out in a fixed priority order. Register-area accesses have a fixed length. Multiplexed external accesses always take the longest form. A global wait bit comes next and overrides the per-chip-select fast bits. The fast bits apply only when the global wait bit is clear.

The controller latches the count when it accepts an access. It then holds a busy flag for that many cycles and pulses a done flag in the last one. Software programs four small registers through a simple write port. An unlock register guards the two mode registers: the clock-control register and the wait-control register. The chip-select fast-bit register is always writable. The clock-control register also decides whether the bus-clock output is driven or floated.

Top module: `bus_wait_ctrl`

## Requirements
- R1: An access with region code 0 (register area) takes 2 cycles, whatever the wait settings are.
- R2: An access with region code 1 (internal memory) takes 1 cycle when the global wait bit is 0, and 2 cycles when it is 1.
- R3: A separate-bus access with region code 2 or 3 (external; 3 is treated as 2) takes 2 cycles when the global wait bit is 1. The chip-select fast bits have no effect in this case.
- R4: When the global wait bit is 0, a separate-bus external access to chip select i takes 1 cycle if fast bit i is 1, and 2 cycles if it is 0. Fast bit i is bit i of the value written with cfg_sel=3. That register can be written at any time.
- R5: A multiplexed external access (acc_mux=1) always takes 3 cycles.
- R6: After reset, the global wait bit, all fast bits, the float bit and the unlock bit are 0. The bus clock output enable is 1 and the block is idle.
- R7: Writes with cfg_sel=1 (float bit = wdata bit 0) or cfg_sel=2 (global wait bit = wdata bit 0) take effect only while the unlock bit is 1. The unlock bit is wdata bit 0 of a write with cfg_sel=0. A write made while locked is dropped and changes nothing.
- R8: bclk_oe equals the inverse of the float bit. A float bit of 1 floats the clock output.
- R9: A request is accepted only when acc_busy is 0. Requests made while busy are ignored and do not start a new access.
- R10: After acceptance, acc_busy is high for exactly the latched number of cycles. acc_done is high only in the last of them, and acc_cycles reports the latched count.
- R11: Writing the wait or fast-bit registers during an access leaves that access's cycle count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 unlock, 1 clock control, 2 wait control, 3 fast bits |
| cfg_wdata | input | NUM_CS | Write data |
| acc_req | input | 1 | Access request |
| acc_region | input | 2 | Region code: 0 register area, 1 internal, 2/3 external |
| acc_cs | input | $clog2(NUM_CS) | Chip-select index |
| acc_mux | input | 1 | 1 = multiplexed bus |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | Last cycle of the access |
| acc_cycles | output | 2 | Latched cycle count of the current or last access |
| bclk_oe | output | 1 | Bus clock output enable (0 = floated) |

## Verification
The bench builds the block with its default of four chip selects. This gives a two-bit index and a four-bit fast mask, so every chip select, including the highest index, can be reached with its own fast bit. A vector table covers every branch of the cycle priority. Directed tests then cover the lock, the clock float, requests made while busy, and register writes made in the middle of an access.

// File: rtl/bw_pkg.sv
// Shared types and constants of the wait-state controller.
// Assumes cycle counts never exceed 3, so they fit in two bits.
package bw_pkg;
    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_INT  = 2'd1,
        RGN_EXT  = 2'd2,
        RGN_EXT2 = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        SEL_UNLOCK = 2'd0,
        SEL_CLKCTL = 2'd1,
        SEL_WAIT   = 2'd2,
        SEL_FAST   = 2'd3
    } cfg_sel_t;

    localparam logic [CNT_W-1:0] CYC_ONE   = 2'd1;
    localparam logic [CNT_W-1:0] CYC_TWO   = 2'd2;
    localparam logic [CNT_W-1:0] CYC_THREE = 2'd3;
endpackage

// File: rtl/bw_cfg_regs.sv
// Configuration registers: unlock, clock float, global wait, chip-select fast bits.
// Assumes a single write port. The unlock bit guards the clock and wait registers only.
module bw_cfg_regs
    import bw_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [NUM_CS-1:0] cfg_wdata,
    output logic              glob_wait,
    output logic              clk_float,
    output logic [NUM_CS-1:0] fast_bits
);
    logic unlock;

    // Register update: the unlock and fast registers are always writable, the mode registers only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock    <= 1'b0;
            glob_wait <= 1'b0;
            clk_float <= 1'b0;
            fast_bits <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_UNLOCK: unlock    <= cfg_wdata[0];
                SEL_CLKCTL: if (unlock) clk_float <= cfg_wdata[0];
                SEL_WAIT:   if (unlock) glob_wait <= cfg_wdata[0];
                default:    fast_bits <= cfg_wdata;
            endcase
        end
    end

    // R7
    locked_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_WAIT && !unlock) |=> $stable(glob_wait));
    // R7
    locked_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_CLKCTL && !unlock) |=> $stable(clk_float));
endmodule

// File: rtl/bw_cycle_sel.sv
// Combinational cycle-count selection in priority order:
// register area, then multiplexed external, then global wait, then fast bit.
// Assumes acc_cs always indexes an existing chip select.
module bw_cycle_sel
    import bw_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [1:0]        region,
    input  logic [CS_W-1:0]   cs,
    input  logic              mux,
    input  logic              glob_wait,
    input  logic [NUM_CS-1:0] fast_bits,
    output logic [CNT_W-1:0]  cycles
);
    logic fast_sel;

    // Pick the fast bit of the addressed chip select.
    always_comb fast_sel = fast_bits[cs];

    // Priority decision for the cycle count.
    always_comb begin
        cycles = CYC_TWO;
        case (region)
            RGN_REG: cycles = CYC_TWO;
            RGN_INT: cycles = glob_wait ? CYC_TWO : CYC_ONE;
            default: begin
                if (mux)             cycles = CYC_THREE;
                else if (glob_wait)  cycles = CYC_TWO;
                else                 cycles = fast_sel ? CYC_ONE : CYC_TWO;
            end
        endcase
    end
endmodule

// File: rtl/bw_access_timer.sv
// Per-access counter: latches the count when it accepts an access, holds busy, flags the last cycle.
// Assumes a count of at least 1.
module bw_access_timer
    import bw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] start_cycles,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cycles_lat
);
    logic [CNT_W-1:0] remain;

    // Accept when idle, then count down to the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            remain     <= '0;
            cycles_lat <= '0;
        end else if (busy) begin
            if (remain == CNT_W'(1)) busy <= 1'b0;
            else                     remain <= remain - CNT_W'(1);
        end else if (start_req) begin
            busy       <= 1'b1;
            remain     <= start_cycles;
            cycles_lat <= start_cycles;
        end
    end

    // The last cycle of an access.
    always_comb done = busy && (remain == CNT_W'(1));

    // R10
    fall_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: rtl/bus_wait_ctrl.sv
// Top of the wait-state controller. It ties the configuration registers, the cycle selection
// and the access timer together, and drives the bus clock output enable.
// Assumes requests are held stable in the cycle in which they are presented.
module bus_wait_ctrl
    import bw_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [NUM_CS-1:0] cfg_wdata,
    input  logic              acc_req,
    input  logic [1:0]        acc_region,
    input  logic [CS_W-1:0]   acc_cs,
    input  logic              acc_mux,
    output logic              acc_busy,
    output logic              acc_done,
    output logic [CNT_W-1:0]  acc_cycles,
    output logic              bclk_oe
);
    logic              glob_wait;
    logic              clk_float;
    logic [NUM_CS-1:0] fast_bits;
    logic [CNT_W-1:0]  sel_cycles;
    logic              accept;

    bw_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .glob_wait(glob_wait), .clk_float(clk_float),
        .fast_bits(fast_bits)
    );

    bw_cycle_sel #(.NUM_CS(NUM_CS)) u_sel (
        .region(acc_region), .cs(acc_cs), .mux(acc_mux), .glob_wait(glob_wait),
        .fast_bits(fast_bits), .cycles(sel_cycles)
    );

    bw_access_timer u_timer (
        .clk(clk), .rst_n(rst_n), .start_req(acc_req), .start_cycles(sel_cycles),
        .busy(acc_busy), .done(acc_done), .cycles_lat(acc_cycles)
    );

    // Clock output is driven unless the float bit is set.
    always_comb bclk_oe = ~clk_float;

    // The condition under which an access is accepted.
    always_comb accept = acc_req && !acc_busy;

    // R1
    reg_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_region == RGN_REG) |=> (acc_cycles == CYC_TWO));
    // R5
    mux_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_region[1] && acc_mux) |=> (acc_cycles == CYC_THREE));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && !acc_done) |=> acc_busy);
    // R11
    count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && !acc_done) |=> $stable(acc_cycles));
endmodule

// File: tb/sim_bus_wait_ctrl.sv
module sim_bus_wait_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [3:0] cfg_wdata = '0;
    logic       acc_req = 1'b0;
    logic [1:0] acc_region = '0;
    logic [1:0] acc_cs = '0;
    logic       acc_mux = 1'b0;
    logic       acc_busy, acc_done, bclk_oe;
    logic [1:0] acc_cycles;
    int checks = 0;
    int failures = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    bus_wait_ctrl #(.NUM_CS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_region(acc_region),
        .acc_cs(acc_cs), .acc_mux(acc_mux), .acc_busy(acc_busy),
        .acc_done(acc_done), .acc_cycles(acc_cycles), .bclk_oe(bclk_oe)
    );

    typedef struct packed {
        logic       gw;
        logic [3:0] fast;
        logic [1:0] rgn;
        logic [1:0] cs;
        logic       mux;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'b0000, 2'd0, 2'd0, 1'b0, 2'd2},  // R1
        '{1'b1, 4'b1111, 2'd0, 2'd1, 1'b1, 2'd2},  // R1
        '{1'b0, 4'b0000, 2'd1, 2'd0, 1'b0, 2'd1},  // R2
        '{1'b1, 4'b0000, 2'd1, 2'd0, 1'b0, 2'd2},  // R2
        '{1'b0, 4'b0001, 2'd2, 2'd0, 1'b0, 2'd1},  // R4
        '{1'b0, 4'b0001, 2'd2, 2'd1, 1'b0, 2'd2},  // R4
        '{1'b0, 4'b1000, 2'd2, 2'd3, 1'b0, 2'd1},  // R4
        '{1'b1, 4'b1111, 2'd2, 2'd3, 1'b0, 2'd2},  // R3
        '{1'b1, 4'b0000, 2'd3, 2'd2, 1'b0, 2'd2},  // R3
        '{1'b0, 4'b1111, 2'd2, 2'd2, 1'b1, 2'd3},  // R5
        '{1'b1, 4'b0000, 2'd2, 2'd1, 1'b1, 2'd3},  // R5
        '{1'b0, 4'b0100, 2'd3, 2'd2, 1'b0, 2'd1}   // R4
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issues one access and counts the busy cycles up to and including done.
    task automatic run_acc(input logic [1:0] rg, input logic [1:0] cs, input logic mx,
                           output int n, output int rep);
        @(negedge clk);
        acc_req = 1'b1; acc_region = rg; acc_cs = cs; acc_mux = mx;
        @(negedge clk);
        acc_req = 1'b0;
        n = 0; rep = -1;
        for (int k = 0; k < 8; k++) begin
            if (acc_busy) n++;
            if (acc_done) begin rep = int'(acc_cycles); break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, rep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(bclk_oe === 1'b1, "R6 oe", int'(bclk_oe), 1);
        chk(acc_busy === 1'b0 && acc_done === 1'b0, "R6 idle", int'(acc_busy), 0);
        run_acc(2'd2, 2'd0, 1'b0, n, rep);
        chk(n == 2, "R6 fast bits clear", n, 2);
        run_acc(2'd1, 2'd0, 1'b0, n, rep);
        chk(n == 1, "R6 wait bit clear", n, 1);

        // R7 locked writes are dropped
        wr(2'd2, 4'h1);
        wr(2'd1, 4'h1);
        run_acc(2'd1, 2'd0, 1'b0, n, rep);
        chk(n == 1, "R7 locked wait write", n, 1);
        chk(bclk_oe === 1'b1, "R7 locked float write", int'(bclk_oe), 1);

        // R4 fast register writable while locked
        wr(2'd3, 4'b0010);
        run_acc(2'd2, 2'd1, 1'b0, n, rep);
        chk(n == 1, "R4 fast write while locked", n, 1);

        // R8 float control when unlocked
        wr(2'd0, 4'h1);
        wr(2'd1, 4'h1);
        @(negedge clk);
        chk(bclk_oe === 1'b0, "R8 float set", int'(bclk_oe), 0);
        wr(2'd1, 4'h0);
        @(negedge clk);
        chk(bclk_oe === 1'b1, "R8 float clear", int'(bclk_oe), 1);

        // Table walk over the cycle priority (R1 R2 R3 R4 R5 R10)
        foreach (VECS[i]) begin
            wr(2'd2, {3'b000, VECS[i].gw});
            wr(2'd3, VECS[i].fast);
            run_acc(VECS[i].rgn, VECS[i].cs, VECS[i].mux, n, rep);
            chk(n == int'(VECS[i].exp), $sformatf("R10 vec%0d busy length", i), n, int'(VECS[i].exp));
            chk(rep == int'(VECS[i].exp), $sformatf("R10 vec%0d reported count", i), rep, int'(VECS[i].exp));
        end

        // R7 relock then write: wait bit stays 0
        wr(2'd2, 4'h0);
        wr(2'd0, 4'h0);
        wr(2'd2, 4'h1);
        run_acc(2'd1, 2'd0, 1'b0, n, rep);
        chk(n == 1, "R7 relocked wait write", n, 1);

        // R11 fast-bit write during an access
        wr(2'd3, 4'h0);
        @(negedge clk);
        acc_req = 1'b1; acc_region = 2'd2; acc_cs = 2'd1; acc_mux = 1'b0;
        @(negedge clk);
        acc_req = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 4'hF;
        n = acc_busy ? 1 : 0;
        @(negedge clk);
        cfg_we = 1'b0;
        if (acc_busy) n++;
        chk(n == 2 && acc_done === 1'b1, "R11 mid-access write length", n, 2);
        chk(acc_cycles == 2'd2, "R11 mid-access count", int'(acc_cycles), 2);
        run_acc(2'd2, 2'd1, 1'b0, n, rep);
        chk(n == 1, "R11 write applies to next access", n, 1);

        // R9 requests while busy are ignored
        wr(2'd0, 4'h1);
        wr(2'd2, 4'h1);
        @(negedge clk);
        acc_req = 1'b1; acc_region = 2'd2; acc_cs = 2'd0; acc_mux = 1'b0;
        @(negedge clk);
        acc_mux = 1'b1;
        chk(acc_busy === 1'b1 && acc_done === 1'b0, "R9 first cycle", int'(acc_done), 0);
        @(negedge clk);
        chk(acc_done === 1'b1 && acc_cycles == 2'd2, "R9 busy request ignored", int'(acc_cycles), 2);
        acc_req = 1'b0;
        @(negedge clk);
        chk(acc_busy === 1'b0, "R9 no access started", int'(acc_busy), 0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule